// File: doc/BRIEF.md
# Exception Return Status Stack Unit

This block performs the status-word side of a return from an exception or from a non-maskable interrupt. The condition code status word keeps earlier flag sets stacked inside a 28-bit field. A return pops that stack by shifting the field right by ten places. The two top bits of the word are not part of the stack and stay where they are. The unit also sets the privilege flag (P) and the NMI mask flag (M) according to the return type and the restart flag (R). When the popped word selects user mode, the unit exchanges the kernel and user stack pointers.

The pipeline drives a one-cycle return strobe with the return type, the current status word, the current stack pointer and the saved user stack pointer. The new status word, the new stack pointer and the saved kernel stack pointer all become valid together after the next rising clock edge. When the strobe is low, the registered outputs hold their values.

Top module: `rfe_status_stack`

## Requirements
- R1: While reset is applied, and after it is released with no return strobe, status_out, sp_out and ksp_out read zero.
- R2: On a return, status_out bit 31 equals bit 31 of status_in. For ret_kind = 0 (exception return), bit 30 also equals status_in bit 30.
- R3: On a return, status_out bits 27 down to 0 equal status_in bits 27 down to 0 shifted right by 10 places, with zeros entering at the top. Bits 29 and 28 of status_out are zero. Bit 7 is the only exception; R4 and R5 define it.
- R4: If the R flag (status_in bit 8, sampled before the shift) is 0, the P flag (status_out bit 7) is 1 after the return.
- R5: If the R flag is 1, status_out bit 7 is the shifted value, which is status_in bit 17.
- R6: When ret_kind = 1 (NMI return), status_out bit 30 (M flag) is 1 whatever its earlier value. All other bits follow R2 to R5.
- R7: If the U flag (bit 6) of the shifted word is 1, which is status_in bit 16, then sp_out takes usp_in and ksp_out takes sp_in.
- R8: If the U flag of the shifted word is 0, sp_out takes sp_in and ksp_out keeps its previous value.
- R9: While ret_valid is low, status_out, sp_out and ksp_out keep their values, whatever the other inputs do.
- R10: All three outputs change on the same clock edge, the first rising edge at which ret_valid is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ret_valid | input | 1 | Return strobe, one cycle per return |
| ret_kind | input | 1 | 0 = exception return, 1 = NMI return |
| status_in | input | 32 | Status word before the return |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| status_out | output | 32 | Status word after the return |
| sp_out | output | 32 | Stack pointer after the return |
| ksp_out | output | 32 | Saved kernel stack pointer |

## Verification
The hardest case to reach is a return that makes the swap decision from a bit that only lands in the U position after the shift. The same return has to keep ksp_out unchanged through a following return that stays in kernel mode. The bench covers this with a pair of returns. The first sets status_in bit 16 and loads a known kernel pointer. The second clears bit 16 and drives a different sp_in, which shows that ksp_out keeps the earlier value. The bench also places the R flag and the pre-shift source of bit 7 in all four combinations. This separates a P flag that is forced to 1 from one that is merely shifted into place.

// File: rtl/rfe_stack_pkg.sv
package rfe_stack_pkg;

  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_FIELD_W = 28;
  localparam int unsigned DEF_KEEP_W  = 2;
  localparam int unsigned DEF_SHIFT   = 10;
  localparam int unsigned DEF_U_BIT   = 6;
  localparam int unsigned DEF_P_BIT   = 7;
  localparam int unsigned DEF_R_BIT   = 8;
  localparam int unsigned DEF_M_BIT   = 30;
  localparam int unsigned DEF_SYNC_N  = 2;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;

endpackage

// File: rtl/rfe_rst_sync.sv
module rfe_rst_sync #(
  parameter int unsigned STAGES = rfe_stack_pkg::DEF_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rfe_status_pop.sv
module rfe_status_pop
  import rfe_stack_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned KEEP_W  = DEF_KEEP_W,
  parameter int unsigned SHIFT   = DEF_SHIFT,
  parameter int unsigned U_BIT   = DEF_U_BIT,
  parameter int unsigned P_BIT   = DEF_P_BIT,
  parameter int unsigned R_BIT   = DEF_R_BIT,
  parameter int unsigned M_BIT   = DEF_M_BIT
) (
  input  logic [WORD_W-1:0] status_in,
  input  ret_kind_e         kind,
  output logic [WORD_W-1:0] status_next,
  output logic              user_mode
);

  localparam logic [WORD_W-1:0] ONES       = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] KEEP_MASK  = ~(ONES >> KEEP_W);
  localparam logic [WORD_W-1:0] FIELD_MASK = ONES >> (WORD_W - FIELD_W);

  logic [WORD_W-1:0] shifted;
  logic              restart_flag;

  always_comb begin
    restart_flag = status_in[R_BIT];
    shifted      = (status_in & KEEP_MASK) | ((status_in & FIELD_MASK) >> SHIFT);
    user_mode    = shifted[U_BIT];
    status_next  = shifted;
    if (!restart_flag) begin
      status_next[P_BIT] = 1'b1;
    end
    if (kind == RET_NMI) begin
      status_next[M_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/rfe_stack_swap.sv
module rfe_stack_swap #(
  parameter int unsigned WORD_W = rfe_stack_pkg::DEF_WORD_W
) (
  input  logic              user_mode,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] usp_in,
  input  logic [WORD_W-1:0] ksp_cur,
  output logic [WORD_W-1:0] sp_next,
  output logic [WORD_W-1:0] ksp_next
);

  always_comb begin
    if (user_mode) begin
      sp_next  = usp_in;
      ksp_next = sp_in;
    end else begin
      sp_next  = sp_in;
      ksp_next = ksp_cur;
    end
  end

endmodule

// File: rtl/rfe_status_stack.sv
module rfe_status_stack
  import rfe_stack_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned KEEP_W  = DEF_KEEP_W,
  parameter int unsigned SHIFT   = DEF_SHIFT,
  parameter int unsigned U_BIT   = DEF_U_BIT,
  parameter int unsigned P_BIT   = DEF_P_BIT,
  parameter int unsigned R_BIT   = DEF_R_BIT,
  parameter int unsigned M_BIT   = DEF_M_BIT,
  parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic              ret_kind,
  input  logic [WORD_W-1:0] status_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] usp_in,
  output logic [WORD_W-1:0] status_out,
  output logic [WORD_W-1:0] sp_out,
  output logic [WORD_W-1:0] ksp_out
);

  logic              rst_sync_n;
  logic [WORD_W-1:0] status_q, status_d, status_pop;
  logic [WORD_W-1:0] sp_q, sp_d, sp_swap;
  logic [WORD_W-1:0] ksp_q, ksp_d, ksp_swap;
  logic              user_mode;
  ret_kind_e         kind;

  assign kind = ret_kind_e'(ret_kind);

  rfe_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfe_status_pop #(
    .WORD_W (WORD_W), .FIELD_W(FIELD_W), .KEEP_W(KEEP_W), .SHIFT(SHIFT),
    .U_BIT  (U_BIT),  .P_BIT  (P_BIT),   .R_BIT (R_BIT),  .M_BIT(M_BIT)
  ) u_pop (
    .status_in   (status_in),
    .kind        (kind),
    .status_next (status_pop),
    .user_mode   (user_mode)
  );

  rfe_stack_swap #(.WORD_W(WORD_W)) u_swap (
    .user_mode (user_mode),
    .sp_in     (sp_in),
    .usp_in    (usp_in),
    .ksp_cur   (ksp_q),
    .sp_next   (sp_swap),
    .ksp_next  (ksp_swap)
  );

  // next-state selection: the strobe is the shared clock enable
  always_comb begin
    status_d = status_q;
    sp_d     = sp_q;
    ksp_d    = ksp_q;
    if (ret_valid) begin
      status_d = status_pop;
      sp_d     = sp_swap;
      ksp_d    = ksp_swap;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
      sp_q     <= '0;
      ksp_q    <= '0;
    end else begin
      status_q <= status_d;
      sp_q     <= sp_d;
      ksp_q    <= ksp_d;
    end
  end

  assign status_out = status_q;
  assign sp_out     = sp_q;
  assign ksp_out    = ksp_q;

endmodule

// File: rtl/rfe_status_stack_checker.sv
module rfe_status_stack_checker #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 28,
  parameter int unsigned SHIFT   = 10,
  parameter int unsigned U_BIT   = 6,
  parameter int unsigned P_BIT   = 7,
  parameter int unsigned R_BIT   = 8,
  parameter int unsigned M_BIT   = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic              ret_kind,
  input logic [WORD_W-1:0] status_in,
  input logic [WORD_W-1:0] sp_in,
  input logic [WORD_W-1:0] usp_in,
  input logic [WORD_W-1:0] status_out,
  input logic [WORD_W-1:0] sp_out,
  input logic [WORD_W-1:0] ksp_out
);

  assert_top_bit_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> status_out[WORD_W-1] == $past(status_in[WORD_W-1]));

  assert_exc_bit30_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_kind) |=> status_out[WORD_W-2] == $past(status_in[WORD_W-2]));

  assert_vacated_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> status_out[WORD_W-3:FIELD_W-SHIFT] == '0);

  assert_p_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !status_in[R_BIT]) |=> status_out[P_BIT]);

  assert_p_shifted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && status_in[R_BIT]) |=> status_out[P_BIT] == $past(status_in[P_BIT+SHIFT]));

  assert_m_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind) |=> status_out[M_BIT]);

  assert_user_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && status_in[U_BIT+SHIFT]) |=>
      (sp_out == $past(usp_in)) && (ksp_out == $past(sp_in)));

  assert_kernel_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !status_in[U_BIT+SHIFT]) |=>
      (sp_out == $past(sp_in)) && $stable(ksp_out));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(status_out) && $stable(sp_out) && $stable(ksp_out));

endmodule

bind rfe_status_stack rfe_status_stack_checker #(
  .WORD_W(WORD_W), .FIELD_W(FIELD_W), .SHIFT(SHIFT),
  .U_BIT(U_BIT), .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ret_valid  (ret_valid),
  .ret_kind   (ret_kind),
  .status_in  (status_in),
  .sp_in      (sp_in),
  .usp_in     (usp_in),
  .status_out (status_out),
  .sp_out     (sp_out),
  .ksp_out    (ksp_out)
);

// File: tb/rfe_status_stack_test.sv
`timescale 1ns/1ps
module rfe_status_stack_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_valid;
  logic        ret_kind;
  logic [31:0] status_in, sp_in, usp_in;
  logic [31:0] status_out, sp_out, ksp_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] ksp_model;

  always #2.5 clk = ~clk;

  rfe_status_stack uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in),
    .status_out(status_out), .sp_out(sp_out), .ksp_out(ksp_out)
  );

  function automatic logic [31:0] model_status(input logic [31:0] s, input logic nmi);
    logic [31:0] o;
    o = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    if (!s[8]) o[7] = 1'b1;
    if (nmi)   o[30] = 1'b1;
    return o;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one return: drive at negedge, captured at next posedge, sampled at next negedge
  task automatic do_return(input logic [31:0] s, input logic nmi,
                           input logic [31:0] sp, input logic [31:0] usp,
                           input string req);
    logic [31:0] exp_sp;
    @(negedge clk);
    ret_valid = 1'b1; ret_kind = nmi; status_in = s; sp_in = sp; usp_in = usp;
    @(negedge clk);
    ret_valid = 1'b0;
    status_in = ~s; sp_in = ~sp; usp_in = ~usp;
    if (s[16]) begin exp_sp = usp; ksp_model = sp; end
    else       exp_sp = sp;
    check(req, "status", status_out, model_status(s, nmi));
    check(req, "sp",     sp_out,     exp_sp);
    check(req, "ksp",    ksp_out,    ksp_model);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ret_valid = 1'b0; ret_kind = 1'b0;
    status_in = '1; sp_in = '1; usp_in = '1;
    ksp_model = '0;
    repeat (3) @(negedge clk);
    check("R1", "status in reset", status_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "status after release", status_out, 32'h0);
    check("R1", "sp after release",     sp_out,     32'h0);
    check("R1", "ksp after release",    ksp_out,    32'h0);
  endtask

  task automatic t_shift_basic;
    // R3: field shift, R4: R clear forces P, exception return
    do_return(32'h0ABC_DE00, 1'b0, 32'h1000, 32'h2000, "R3");
    check("R4", "P bit", {31'h0, status_out[7]}, 32'h1);
  endtask

  task automatic t_keep_top;
    // R2: top bits kept, bits 29:28 cleared
    do_return(32'hF000_0000, 1'b0, 32'h1111, 32'h2222, "R2");
    check("R3", "bits 29:28", {30'h0, status_out[29:28]}, 32'h0);
    do_return(32'h8000_0100, 1'b0, 32'h1111, 32'h2222, "R2");
  endtask

  task automatic t_p_combos;
    // R5: R set -> P is shifted copy of bit 17
    do_return(32'h0002_0100, 1'b0, 32'h10, 32'h20, "R5");
    check("R5", "P from bit17 set", {31'h0, status_out[7]}, 32'h1);
    do_return(32'h0000_0100, 1'b0, 32'h10, 32'h20, "R5");
    check("R5", "P from bit17 clear", {31'h0, status_out[7]}, 32'h0);
    do_return(32'h0000_0000, 1'b0, 32'h10, 32'h20, "R4");
    do_return(32'h0002_0000, 1'b0, 32'h10, 32'h20, "R4");
  endtask

  task automatic t_nmi;
    do_return(32'h0000_0100, 1'b1, 32'h30, 32'h40, "R6");
    check("R6", "M bit", {31'h0, status_out[30]}, 32'h1);
    do_return(32'h4000_0100, 1'b1, 32'h30, 32'h40, "R6");
  endtask

  task automatic t_swap_pair;
    // R7 then R8: kernel pointer saved, then retained over a kernel return
    do_return(32'h0001_0000, 1'b0, 32'hAAAA_0000, 32'hBBBB_0000, "R7");
    check("R7", "ksp saved", ksp_out, 32'hAAAA_0000);
    check("R10", "sp same edge", sp_out, 32'hBBBB_0000);
    do_return(32'h0000_0000, 1'b1, 32'hCCCC_0000, 32'hDDDD_0000, "R8");
    check("R8", "ksp retained", ksp_out, 32'hAAAA_0000);
  endtask

  task automatic t_idle_hold;
    logic [31:0] s0, p0, k0;
    s0 = status_out; p0 = sp_out; k0 = ksp_out;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      ret_kind = i[0]; status_in = 32'h5A5A_5A5A ^ i; sp_in = 32'h77 + i; usp_in = 32'h99 - i;
    end
    @(negedge clk);
    check("R9", "status held", status_out, s0);
    check("R9", "sp held",     sp_out,     p0);
    check("R9", "ksp held",    ksp_out,    k0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++) begin
      do_return($urandom, 1'($urandom), $urandom, $urandom, "R3");
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_basic();
    t_keep_top();
    t_p_combos();
    t_nmi();
    t_swap_pair();
    t_idle_hold();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule